// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns a decoded operand specifier into a 16-bit operand address for a processor whose data space is 64 KB. The decoder presents a mode code, the base register contents, a displacement or absolute field together with a code for its width, the operand size and the address of the following instruction, and raises `start` for one cycle. For most modes the block returns the address one cycle later on `ea_valid`. The auto-increment and auto-decrement modes also return a new base register value on `wb_val`, qualified by `wb_en`. Register-direct and immediate operands raise `no_mem` and carry no address.

In memory-indirect mode the operand field selects a 16-bit pointer in the bottom page. The block holds a read request until the memory acknowledges it, and the returned word becomes the address. While that fetch is pending the block reports `busy` and ignores `start`. Any field wider than the address space is cut to 16 bits. Short fields are sign-extended before they are added.

Top module: `ea_gen`

## Requirements
- R1: After reset, `ea_valid`, `mem_req`, `wb_en` and `busy` are all low.
- R2: When the block is idle, `start` with any mode other than memory-indirect (mode 8) produces exactly one `ea_valid` pulse in the next cycle. While `busy` is high, `start` is ignored and produces no pulse. `ea_valid` is never high without an accepted request.
- R3: In register indirect mode (mode 1) the address is the low 16 bits of `base`.
- R4: In register-plus-displacement mode (mode 2) the address is `base` plus the field, modulo 2^16. The width code (`fwidth`: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 24-bit) decides how the field is read. An 8-bit field is sign-extended. Wider fields contribute their low 16 bits.
- R5: In post-increment mode (mode 3) the address is the low 16 bits of `base`, and `wb_val` = `base` + step with `wb_en` high. The step is 1, 2 or 4 for `size` 0 (byte), 1 (word) and 2 or 3 (long).
- R6: In pre-decrement mode (mode 4), `wb_val` = `base` − step with `wb_en` high, and the address is the low 16 bits of that decremented value.
- R7: In absolute mode (mode 5), an 8-bit field maps to 0xFF00 + field. A 16-bit or 24-bit field gives its low 16 bits.
- R8: In PC-relative mode (mode 7) the address is `pc` plus the field, modulo 2^16. An 8-bit field is sign-extended.
- R9: Register-direct (mode 0), immediate (mode 6) and unused codes 9–15 raise `no_mem`, give an address of 0 and keep `wb_en` low.
- R10: Memory-indirect mode (mode 8) raises `mem_req` with `mem_addr` = 0x00 concatenated with field[7:0]. `mem_req` and `mem_addr` stay constant until `mem_ack`. The cycle after `mem_ack`, `ea_valid` rises with the address equal to the `mem_rdata` sampled with the acknowledge, and `mem_req` falls.
- R11: In every mode other than 3 and 4, `wb_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, one cycle |
| mode | input | 4 | Addressing mode code |
| base | input | 32 | Base register value |
| field | input | 24 | Displacement or absolute field |
| fwidth | input | 2 | Field width code |
| size | input | 2 | Operand size code |
| pc | input | 16 | Address of the next instruction |
| mem_rdata | input | 16 | Pointer word returned by memory |
| mem_ack | input | 1 | Pointer read acknowledge |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 16 | Pointer address |
| ea | output | 16 | Effective address |
| ea_valid | output | 1 | Address valid pulse |
| no_mem | output | 1 | Operand is not in memory |
| wb_en | output | 1 | Base writeback enable |
| wb_val | output | 32 | Updated base value |
| busy | output | 1 | Pointer fetch in progress |

## Verification
The assertions assume two things about the memory side: `mem_ack` arrives only while `mem_req` is high, and `mem_rdata` is valid in the same cycle as the acknowledge. The bench raises the acknowledge only after it has seen the request, and drives the read data together with it. The assertions also assume that `start` lasts a single cycle. The bench drives each strobe for exactly one cycle. It tries a second strobe only while a fetch is pending, to show that the strobe is ignored.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [3:0] {
        MD_REG     = 4'd0,
        MD_IND     = 4'd1,
        MD_DISP    = 4'd2,
        MD_POSTINC = 4'd3,
        MD_PREDEC  = 4'd4,
        MD_ABS     = 4'd5,
        MD_IMM     = 4'd6,
        MD_PCREL   = 4'd7,
        MD_MEMIND  = 4'd8
    } ea_mode_e;

    typedef enum logic [1:0] {
        FW_8  = 2'd0,
        FW_16 = 2'd1,
        FW_24 = 2'd2
    } fw_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } sz_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } ea_state_e;
endpackage

// File: rtl/ea_offset.sv
// Field interpretation: signed offset for adds, page-mapped absolute address.
module ea_offset #(
    parameter int AW = 16,
    parameter int FW = 24
) (
    input  logic [FW-1:0] field,
    input  logic [1:0]    fwidth,
    output logic [AW-1:0] offset,
    output logic [AW-1:0] abs_addr
);
    import ea_pkg::*;

    logic [FW-1:0] ext8;
    logic [FW-1:0] ext16;

    always_comb begin
        ext8  = {{(FW-8){field[7]}}, field[7:0]};
        ext16 = {{(FW-16){field[15]}}, field[15:0]};
        case (fwidth)
            FW_8:    offset = ext8[AW-1:0];
            FW_16:   offset = ext16[AW-1:0];
            default: offset = field[AW-1:0];
        endcase
        if (fwidth == FW_8)
            abs_addr = {{(AW-8){1'b1}}, field[7:0]};
        else
            abs_addr = field[AW-1:0];
    end
endmodule

// File: rtl/ea_step.sv
// Auto-modify step: operand size in bytes.
module ea_step #(
    parameter int RW = 32
) (
    input  logic [1:0]    size,
    output logic [RW-1:0] step
);
    import ea_pkg::*;

    always_comb begin
        step = '0;
        case (size)
            SZ_BYTE: step[0] = 1'b1;
            SZ_WORD: step[1] = 1'b1;
            default: step[2] = 1'b1;
        endcase
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
    parameter int AW = 16,
    parameter int RW = 32,
    parameter int FW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [RW-1:0] base,
    input  logic [FW-1:0] field,
    input  logic [1:0]    fwidth,
    input  logic [1:0]    size,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] ea,
    output logic          ea_valid,
    output logic          no_mem,
    output logic          wb_en,
    output logic [RW-1:0] wb_val,
    output logic          busy
);
    import ea_pkg::*;

    localparam int PAGE_W = 8;

    typedef struct packed {
        ea_state_e     state;
        logic [AW-1:0] ea;
        logic          valid;
        logic          no_mem;
        logic          wb_en;
        logic [RW-1:0] wb_val;
        logic          mem_req;
        logic [AW-1:0] mem_addr;
    } ea_regs_t;

    ea_regs_t r_q, r_d;

    logic [AW-1:0] offset;
    logic [AW-1:0] abs_addr;
    logic [RW-1:0] step;
    logic [RW-1:0] dec_base;

    ea_offset #(.AW(AW), .FW(FW)) u_offset (
        .field   (field),
        .fwidth  (fwidth),
        .offset  (offset),
        .abs_addr(abs_addr)
    );

    ea_step #(.RW(RW)) u_step (
        .size(size),
        .step(step)
    );

    always_comb begin
        dec_base = base - step;
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.wb_en = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.valid  = 1'b1;
                    r_d.no_mem = 1'b0;
                    r_d.ea     = '0;
                    r_d.wb_val = base;
                    case (mode)
                        MD_IND:  r_d.ea = base[AW-1:0];
                        MD_DISP: r_d.ea = base[AW-1:0] + offset;
                        MD_POSTINC: begin
                            r_d.ea     = base[AW-1:0];
                            r_d.wb_en  = 1'b1;
                            r_d.wb_val = base + step;
                        end
                        MD_PREDEC: begin
                            r_d.ea     = dec_base[AW-1:0];
                            r_d.wb_en  = 1'b1;
                            r_d.wb_val = dec_base;
                        end
                        MD_ABS:   r_d.ea = abs_addr;
                        MD_PCREL: r_d.ea = pc + offset;
                        MD_MEMIND: begin
                            r_d.valid    = 1'b0;
                            r_d.state    = ST_FETCH;
                            r_d.mem_req  = 1'b1;
                            r_d.mem_addr = {{(AW-PAGE_W){1'b0}}, field[PAGE_W-1:0]};
                        end
                        default: r_d.no_mem = 1'b1;
                    endcase
                end
            end
            default: begin
                if (mem_ack) begin
                    r_d.state   = ST_IDLE;
                    r_d.mem_req = 1'b0;
                    r_d.valid   = 1'b1;
                    r_d.ea      = mem_rdata;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, ea: '0, valid: 1'b0, no_mem: 1'b0,
                     wb_en: 1'b0, wb_val: '0, mem_req: 1'b0, mem_addr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req  = r_q.mem_req;
    assign mem_addr = r_q.mem_addr;
    assign ea       = r_q.ea;
    assign ea_valid = r_q.valid;
    assign no_mem   = r_q.no_mem;
    assign wb_en    = r_q.wb_en;
    assign wb_val   = r_q.wb_val;
    assign busy     = (r_q.state == ST_FETCH);

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode != MD_MEMIND) |=> ea_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |-> ($past(start) && !$past(busy)) || $past(mem_ack));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_ptr_page_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[AW-1:PAGE_W] == '0));

    assert_wb_qual_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (ea_valid && !no_mem && $past(mode) inside {MD_POSTINC, MD_PREDEC}));

    assert_busy_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> mem_req);
endmodule

// File: tb/ea_gen_test.sv
module ea_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [31:0] base = '0;
    logic [23:0] field = '0;
    logic [1:0]  fwidth = '0;
    logic [1:0]  size = '0;
    logic [15:0] pc = '0;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [15:0] ea;
    logic        ea_valid;
    logic        no_mem;
    logic        wb_en;
    logic [31:0] wb_val;
    logic        busy;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    ea_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
        .field(field), .fwidth(fwidth), .size(size), .pc(pc),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_req(mem_req),
        .mem_addr(mem_addr), .ea(ea), .ea_valid(ea_valid), .no_mem(no_mem),
        .wb_en(wb_en), .wb_val(wb_val), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sext(input logic [23:0] f, input logic [1:0] w);
        if (w == 2'd0) return {{8{f[7]}}, f[7:0]};
        return f[15:0];
    endfunction

    function automatic logic [31:0] stepof(input logic [1:0] s);
        return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    task automatic run_op(input logic [3:0] m, input logic [31:0] b,
                          input logic [23:0] f, input logic [1:0] w,
                          input logic [1:0] s, input logic [15:0] p,
                          input logic [15:0] exp_ea, input bit exp_nm,
                          input bit exp_wb, input logic [31:0] exp_wbv,
                          input string req);
        @(negedge clk);
        mode = m; base = b; field = f; fwidth = w; size = s; pc = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(ea_valid == 1'b1, {"R2 valid ", req}, 32'(ea_valid), 32'd1);
        chk(ea == exp_ea, req, 32'(ea), 32'(exp_ea));
        chk(no_mem == exp_nm, {req, " no_mem"}, 32'(no_mem), 32'(exp_nm));
        chk(wb_en == exp_wb, {"R11 wb_en ", req}, 32'(wb_en), 32'(exp_wb));
        if (exp_wb) chk(wb_val == exp_wbv, {req, " wb_val"}, wb_val, exp_wbv);
        @(negedge clk);
        chk(ea_valid == 1'b0, {"R2 single pulse ", req}, 32'(ea_valid), 32'd0);
    endtask

    task automatic run_ind(input logic [23:0] f, input logic [15:0] ptr, input int waitc,
                           input bit poke);
        logic [15:0] a;
        a = {8'h00, f[7:0]};
        @(negedge clk);
        mode = 4'd8; field = f; fwidth = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(mem_req == 1'b1, "R10 req", 32'(mem_req), 32'd1);
        chk(mem_addr == a, "R10 addr", 32'(mem_addr), 32'(a));
        chk(ea_valid == 1'b0, "R10 no early valid", 32'(ea_valid), 32'd0);
        if (poke) begin
            mode = 4'd1; base = 32'h1234; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(ea_valid == 1'b0, "R2 start ignored while busy", 32'(ea_valid), 32'd0);
        end
        for (int i = 0; i < waitc; i++) begin
            @(negedge clk);
            chk(mem_req == 1'b1 && mem_addr == a, "R10 hold", 32'(mem_addr), 32'(a));
        end
        mem_ack = 1'b1; mem_rdata = ptr;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = 16'hDEAD;
        chk(ea_valid == 1'b1, "R10 valid after ack", 32'(ea_valid), 32'd1);
        chk(ea == ptr, "R10 pointer", 32'(ea), 32'(ptr));
        chk(mem_req == 1'b0, "R10 req drop", 32'(mem_req), 32'd0);
        chk(busy == 1'b0, "R10 idle", 32'(busy), 32'd0);
        @(negedge clk);
        chk(ea_valid == 1'b0, "R2 single pulse ind", 32'(ea_valid), 32'd0);
    endtask

    logic [31:0] bases [6] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_7FFF,
                               32'h0000_FFFF, 32'h0012_8000, 32'hFFFF_FFFE};
    logic [23:0] fields [8] = '{24'h000000, 24'h000001, 24'h00007F, 24'h000080,
                                24'h0000FF, 24'h007FFF, 24'h00FFFE, 24'hFF8001};

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ea_valid == 0 && mem_req == 0 && wb_en == 0 && busy == 0, "R1 reset",
            {ea_valid, mem_req, wb_en, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ea_valid == 0 && busy == 0, "R1 after release", 32'(ea_valid), 32'd0);

        foreach (bases[bi]) begin
            logic [31:0] b;
            b = bases[bi];
            run_op(4'd1, b, 24'h0, 2'd1, 2'd0, 16'h0, b[15:0], 1'b0, 1'b0, 32'h0, "R3 indirect");
            for (int s = 0; s < 4; s++) begin
                logic [31:0] d;
                d = b - stepof(2'(s));
                run_op(4'd3, b, 24'h0, 2'd0, 2'(s), 16'h0, b[15:0], 1'b0, 1'b1,
                       b + stepof(2'(s)), "R5 postinc");
                run_op(4'd4, b, 24'h0, 2'd0, 2'(s), 16'h0, d[15:0], 1'b0, 1'b1, d, "R6 predec");
            end
            foreach (fields[fi]) begin
                for (int w = 0; w < 4; w++)
                    run_op(4'd2, b, fields[fi], 2'(w), 2'd1, 16'h0,
                           b[15:0] + sext(fields[fi], 2'(w)), 1'b0, 1'b0, 32'h0, "R4 disp");
            end
        end

        foreach (fields[fi]) begin
            logic [23:0] f;
            f = fields[fi];
            run_op(4'd5, 32'h5555, f, 2'd0, 2'd0, 16'h0, {8'hFF, f[7:0]}, 1'b0, 1'b0, 32'h0, "R7 abs8");
            run_op(4'd5, 32'h5555, f, 2'd1, 2'd0, 16'h0, f[15:0], 1'b0, 1'b0, 32'h0, "R7 abs16");
            run_op(4'd5, 32'h5555, f, 2'd2, 2'd0, 16'h0, f[15:0], 1'b0, 1'b0, 32'h0, "R7 abs24");
            for (int w = 0; w < 2; w++) begin
                run_op(4'd7, 32'h0, f, 2'(w), 2'd0, 16'h1000,
                       16'h1000 + sext(f, 2'(w)), 1'b0, 1'b0, 32'h0, "R8 pcrel");
                run_op(4'd7, 32'h0, f, 2'(w), 2'd0, 16'hFFF0,
                       16'hFFF0 + sext(f, 2'(w)), 1'b0, 1'b0, 32'h0, "R8 pcrel wrap");
            end
        end

        for (int m = 0; m < 16; m++) begin
            if (m == 0 || m == 6 || m >= 9)
                run_op(4'(m), 32'h0000_4321, 24'h00ABCD, 2'd1, 2'd2, 16'h2222,
                       16'h0, 1'b1, 1'b0, 32'h0, "R9 no-memory");
        end

        run_ind(24'h000010, 16'hBEEF, 0, 1'b0);
        run_ind(24'hABCDFE, 16'h0102, 3, 1'b1);
        run_ind(24'h0000FF, 16'hFFFF, 1, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule